// File: doc/BRIEF.md
# Luma Contrast Stretch with Selectable Gamma

This block sits in a pixel-clock video pipeline and reshapes the brightness of one 8-bit component (the luma field) of a 24-bit pixel word. While a frame streams through, it records the darkest and brightest luma values among the valid pixels. When the vertical sync pulse starts, those two limits are captured. A reciprocal of their span is prepared during vertical blanking. Every valid pixel of the following frame is then remapped linearly so that the captured range spreads over the full 0..255 scale.

The stretched value then passes through one of three gamma curves: linear, square-root-like (exponent 0.5) or an exponent-2.5 curve. A fourth code bypasses both stretching and gamma and forwards the raw luma. A manual switch lets externally held limit values replace the measured ones. The other two components of the word and the three timing strobes travel through a delay line of the same length as the luma pipeline, so the output stream stays aligned.

Top module: `luma_stretch_gamma`

## Requirements
- R1: After reset every output is 0, and the active limits are low=0 and high=255, so that with code 0 the luma of a pixel leaves the block unchanged until the first vsync rising edge.
- R2: `dataEnOut`, `hsyncOut`, `vsyncOut` and pixel bits [15:0] equal the corresponding inputs exactly 3 clock cycles earlier. The luma field, bits [23:16], has the same 3-cycle latency.
- R3: At each rising edge of `vsyncIn`, the smallest and largest luma among pixels with `dataEnIn`=1 since the previous rising edge become the active limits. The accumulators restart at 255 and 0, and a pixel that is valid in the edge cycle itself is not counted. The new limits apply to pixels entering at least 32 cycles after the edge. No limit change reaches the datapath in a cycle where `dataEnIn` is 1, provided that vsync timing is respected.
- R4: With limits lo < hi, let recip = floor(255*65536/(hi-lo)) and d = luma-lo, with d = 0 when luma < lo. The stretched value is then min(255, floor(d*recip/65536)).
- R5: When hi <= lo, for example after a flat frame or a frame with no valid pixels, the stretched value equals the input luma.
- R6: `gammaSel` travels with its pixel. Code 0 outputs the stretched value s. Code 1 outputs floor(sqrt(255*s)). Code 2 outputs floor(s*s*floor(sqrt(255*s))/65025).
- R7: `gammaSel`=3 outputs the raw input luma, with no stretch and no gamma.
- R8: If `manualEn` is 1 at a vsync rising edge, `manualLo` and `manualHi` become the active limits instead of the measured ones. The accumulators still restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixIn | input | 24 | Input pixel word, luma in bits [23:16] |
| dataEnIn | input | 1 | Input pixel valid |
| hsyncIn | input | 1 | Input horizontal sync |
| vsyncIn | input | 1 | Input vertical sync, active high |
| gammaSel | input | 2 | Curve code for this pixel: 0 linear, 1 exp 0.5, 2 exp 2.5, 3 bypass |
| manualEn | input | 1 | Use the manual limits at the next vsync edge |
| manualLo | input | 8 | Manual lower limit |
| manualHi | input | 8 | Manual upper limit |
| pixOut | output | 24 | Output pixel word |
| dataEnOut | output | 1 | Delayed pixel valid |
| hsyncOut | output | 1 | Delayed horizontal sync |
| vsyncOut | output | 1 | Delayed vertical sync |

## Verification
The assertions rely on the input timing that video normally has. A vsync rising edge only occurs in blanking. At least 32 cycles without valid pixels follow it, so the serial reciprocal finishes before the next frame. At least 3 idle cycles precede it, so no in-flight pixel sees a limit change. The stimulus builds each frame with 40 vsync-high blank cycles followed by 4 quiet cycles, and it closes every line with 3 idle cycles, so every limit update lands in a gap. Under these conditions, the latency, bypass and no-span properties hold for every valid pixel.

// File: rtl/lsg_pkg.sv
`timescale 1ns/1ps
package lsg_pkg;
  localparam int PIX_W      = 8;
  localparam int MAX_V      = (1 << PIX_W) - 1;
  localparam int FRAC_W     = 16;
  localparam int RECIP_W    = PIX_W + FRAC_W;
  localparam int LUT_N      = 1 << PIX_W;
  localparam int PIPE_DEPTH = 3;

  typedef logic [PIX_W-1:0] pix_t;

  typedef enum logic [1:0] {
    GAMMA_LIN    = 2'd0,
    GAMMA_SQRT   = 2'd1,
    GAMMA_POW25  = 2'd2,
    GAMMA_BYPASS = 2'd3
  } gamma_e;

  // Control-to-datapath strobe bus: fields are valid when commit pulses.
  typedef struct packed {
    logic               commit;
    pix_t               lo;
    logic               noSpan;
    logic [RECIP_W-1:0] recip;
  } limit_bus_t;

  localparam logic [RECIP_W-1:0] UNITY_RECIP = RECIP_W'(1) << FRAC_W;

  // Integer square root, one bit per iteration.
  function automatic int rootOf(input int v);
    int r;
    r = 0;
    for (int b = PIX_W - 1; b >= 0; b--) begin
      if ((r + (1 << b)) * (r + (1 << b)) <= v) r = r + (1 << b);
    end
    return r;
  endfunction

  function automatic int pow25Of(input int v);
    return (v * v * rootOf(v * MAX_V)) / (MAX_V * MAX_V);
  endfunction
endpackage

// File: rtl/lsg_ctrl.sv
`timescale 1ns/1ps
module lsg_ctrl
  import lsg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pix_t       lumaIn,
  input  logic       dataEn,
  input  logic       vsync,
  input  logic       manualEn,
  input  pix_t       manualLo,
  input  pix_t       manualHi,
  output limit_bus_t limBus
);
  localparam int CNT_W = $clog2(RECIP_W);
  localparam logic [CNT_W-1:0]   LAST_STEP = CNT_W'(RECIP_W - 1);
  localparam logic [RECIP_W-1:0] DIVIDEND  = RECIP_W'(MAX_V) << FRAC_W;
  localparam pix_t PIX_MAX = '1;

  logic vsPrev, frameEdge, busy, fits;
  pix_t accLo, accHi, selLo, selHi, span, pendLo, rem, remNext;
  logic [CNT_W-1:0]   stepCnt;
  logic [RECIP_W-1:0] quo, quoNext;
  logic [PIX_W:0]     remShift;

  always_comb begin
    frameEdge = vsync & ~vsPrev;
    selLo     = manualEn ? manualLo : accLo;
    selHi     = manualEn ? manualHi : accHi;
    remShift  = {rem, quo[RECIP_W-1]};
    fits      = remShift >= {1'b0, span};
    remNext   = fits ? pix_t'(remShift - {1'b0, span}) : pix_t'(remShift);
    quoNext   = {quo[RECIP_W-2:0], fits};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vsPrev  <= 1'b0;
      accLo   <= PIX_MAX;
      accHi   <= '0;
      busy    <= 1'b0;
      stepCnt <= '0;
      rem     <= '0;
      quo     <= '0;
      span    <= '0;
      pendLo  <= '0;
      limBus  <= '{commit: 1'b0, lo: '0, noSpan: 1'b0, recip: UNITY_RECIP};
    end else begin
      vsPrev        <= vsync;
      limBus.commit <= 1'b0;
      if (frameEdge) begin
        accLo  <= PIX_MAX;
        accHi  <= '0;
        pendLo <= selLo;
        if (selHi > selLo) begin
          busy    <= 1'b1;
          span    <= selHi - selLo;
          stepCnt <= '0;
          rem     <= '0;
          quo     <= DIVIDEND;
        end else begin
          busy          <= 1'b0;
          limBus.commit <= 1'b1;
          limBus.lo     <= selLo;
          limBus.noSpan <= 1'b1;
        end
      end else begin
        if (dataEn) begin
          if (lumaIn < accLo) accLo <= lumaIn;
          if (lumaIn > accHi) accHi <= lumaIn;
        end
        if (busy) begin
          rem     <= remNext;
          quo     <= quoNext;
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) begin
            busy          <= 1'b0;
            limBus.commit <= 1'b1;
            limBus.lo     <= pendLo;
            limBus.noSpan <= 1'b0;
            limBus.recip  <= quoNext;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lsg_datapath.sv
`timescale 1ns/1ps
module lsg_datapath
  import lsg_pkg::*;
#(
  parameter int NUM_COMP = 3,
  parameter int LUMA_IDX = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_COMP*PIX_W-1:0]   pixIn,
  input  logic                        dataEnIn,
  input  logic                        hsyncIn,
  input  logic                        vsyncIn,
  input  logic [1:0]                  gammaSel,
  input  limit_bus_t                  limBus,
  output logic [NUM_COMP*PIX_W-1:0]   pixOut,
  output logic                        dataEnOut,
  output logic                        hsyncOut,
  output logic                        vsyncOut
);
  localparam int WORD_W = NUM_COMP * PIX_W;
  localparam int SIDE_W = WORD_W + 3;
  localparam int PROD_W = PIX_W + RECIP_W;
  localparam int LSB    = LUMA_IDX * PIX_W;
  localparam pix_t PIX_MAX = '1;

  // Curve tables, computed per entry.
  pix_t sqrtLut [LUT_N];
  pix_t powLut  [LUT_N];
  for (genvar i = 0; i < LUT_N; i++) begin : g_lut
    assign sqrtLut[i] = pix_t'(rootOf(i * MAX_V));
    assign powLut[i]  = pix_t'(pow25Of(i));
  end

  // Active limits, loaded on the commit strobe.
  pix_t               actLo;
  logic               actNoSpan;
  logic [RECIP_W-1:0] actRecip;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actLo     <= '0;
      actNoSpan <= 1'b0;
      actRecip  <= UNITY_RECIP;
    end else if (limBus.commit) begin
      actLo     <= limBus.lo;
      actNoSpan <= limBus.noSpan;
      actRecip  <= limBus.recip;
    end
  end

  pix_t lumaIn;
  assign lumaIn = pixIn[LSB +: PIX_W];

  // Stage 1: offset removal; stage 2: scale and saturate; stage 3: curve.
  pix_t s1Diff, s1Raw, s2Str, s2Raw, s3Luma, stretched;
  logic s1Pass;
  logic [1:0] s1Sel, s2Sel;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-FRAC_W-1:0] scaled;

  always_comb begin
    prod      = PROD_W'(s1Diff) * PROD_W'(actRecip);
    scaled    = prod[PROD_W-1:FRAC_W];
    stretched = (|scaled[PROD_W-FRAC_W-1:PIX_W]) ? PIX_MAX : scaled[PIX_W-1:0];
    if (s1Pass) stretched = s1Raw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Diff <= '0; s1Raw <= '0; s1Pass <= 1'b0; s1Sel <= '0;
      s2Str  <= '0; s2Raw <= '0; s2Sel  <= '0;
      s3Luma <= '0;
    end else begin
      s1Diff <= (lumaIn >= actLo) ? lumaIn - actLo : '0;
      s1Raw  <= lumaIn;
      s1Pass <= actNoSpan;
      s1Sel  <= gammaSel;
      s2Str  <= stretched;
      s2Raw  <= s1Raw;
      s2Sel  <= s1Sel;
      case (gamma_e'(s2Sel))
        GAMMA_LIN:   s3Luma <= s2Str;
        GAMMA_SQRT:  s3Luma <= sqrtLut[s2Str];
        GAMMA_POW25: s3Luma <= powLut[s2Str];
        default:     s3Luma <= s2Raw;
      endcase
    end
  end

  // Side path: strobes and untouched components.
  logic [SIDE_W-1:0] sideDly [PIPE_DEPTH];
  for (genvar k = 0; k < PIPE_DEPTH; k++) begin : g_side
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sideDly[k] <= '0;
      else if (k == 0) sideDly[k] <= {dataEnIn, hsyncIn, vsyncIn, pixIn};
      else sideDly[k] <= sideDly[(k == 0) ? 0 : k-1];
    end
  end

  always_comb begin
    {dataEnOut, hsyncOut, vsyncOut, pixOut} = sideDly[PIPE_DEPTH-1];
    pixOut[LSB +: PIX_W] = s3Luma;
  end
endmodule

// File: rtl/luma_stretch_gamma.sv
`timescale 1ns/1ps
module luma_stretch_gamma
  import lsg_pkg::*;
#(
  parameter int NUM_COMP = 3,
  parameter int LUMA_IDX = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_COMP*PIX_W-1:0] pixIn,
  input  logic                      dataEnIn,
  input  logic                      hsyncIn,
  input  logic                      vsyncIn,
  input  logic [1:0]                gammaSel,
  input  logic                      manualEn,
  input  logic [PIX_W-1:0]          manualLo,
  input  logic [PIX_W-1:0]          manualHi,
  output logic [NUM_COMP*PIX_W-1:0] pixOut,
  output logic                      dataEnOut,
  output logic                      hsyncOut,
  output logic                      vsyncOut
);
  localparam int WORD_W = NUM_COMP * PIX_W;

  limit_bus_t limBus;

  lsg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lumaIn   (pixIn[LUMA_IDX*PIX_W +: PIX_W]),
    .dataEn   (dataEnIn),
    .vsync    (vsyncIn),
    .manualEn (manualEn),
    .manualLo (manualLo),
    .manualHi (manualHi),
    .limBus   (limBus)
  );

  lsg_datapath #(.NUM_COMP(NUM_COMP), .LUMA_IDX(LUMA_IDX)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pixIn     (pixIn),
    .dataEnIn  (dataEnIn),
    .hsyncIn   (hsyncIn),
    .vsyncIn   (vsyncIn),
    .gammaSel  (gammaSel),
    .limBus    (limBus),
    .pixOut    (pixOut),
    .dataEnOut (dataEnOut),
    .hsyncOut  (hsyncOut),
    .vsyncOut  (vsyncOut)
  );
endmodule

// File: rtl/lsg_checker.sv
`timescale 1ns/1ps
module lsg_checker
  import lsg_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int LUMA_IDX = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] pixIn,
  input logic              dataEnIn,
  input logic              hsyncIn,
  input logic              vsyncIn,
  input logic [1:0]        gammaSel,
  input logic [WORD_W-1:0] pixOut,
  input logic              dataEnOut,
  input logic              hsyncOut,
  input logic              vsyncOut,
  input limit_bus_t        limBus
);
  localparam int LSB = LUMA_IDX * PIX_W;
  localparam logic [WORD_W-1:0] LUMA_MASK = WORD_W'({PIX_W{1'b1}}) << LSB;

  // Cycles since reset release, saturating at the pipeline depth.
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3) |-> ({dataEnOut, hsyncOut, vsyncOut} ==
                        $past({dataEnIn, hsyncIn, vsyncIn}, 3)));

  assert_chroma_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3) |-> ((pixOut & ~LUMA_MASK) == ($past(pixIn, 3) & ~LUMA_MASK)));

  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((warm == 2'd3) && ($past(gammaSel, 3) == 2'd3)) |->
      (pixOut[LSB +: PIX_W] == $past(pixIn[LSB +: PIX_W], 3)));

  assert_nospan_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((warm == 2'd3) && $past(dataEnIn, 3) && ($past(gammaSel, 3) == 2'd0) &&
     $past(limBus.noSpan, 3)) |->
      (pixOut[LSB +: PIX_W] == $past(pixIn[LSB +: PIX_W], 3)));

  assert_no_load_active_R3: assert property (@(posedge clk) disable iff (!rstN)
    dataEnIn |-> !limBus.commit);
endmodule

bind luma_stretch_gamma lsg_checker #(.WORD_W(WORD_W), .LUMA_IDX(LUMA_IDX)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pixIn     (pixIn),
  .dataEnIn  (dataEnIn),
  .hsyncIn   (hsyncIn),
  .vsyncIn   (vsyncIn),
  .gammaSel  (gammaSel),
  .pixOut    (pixOut),
  .dataEnOut (dataEnOut),
  .hsyncOut  (hsyncOut),
  .vsyncOut  (vsyncOut),
  .limBus    (limBus)
);

// File: tb/luma_stretch_gamma_tb.sv
`timescale 1ns/1ps
module luma_stretch_gamma_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN;
  logic [23:0] pixIn;
  logic        dataEnIn, hsyncIn, vsyncIn, manualEn;
  logic [1:0]  gammaSel;
  logic [7:0]  manualLo, manualHi;
  logic [23:0] pixOut;
  logic        dataEnOut, hsyncOut, vsyncOut;

  luma_stretch_gamma u_dut (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .dataEnIn(dataEnIn),
    .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .gammaSel(gammaSel),
    .manualEn(manualEn), .manualLo(manualLo), .manualHi(manualHi),
    .pixOut(pixOut), .dataEnOut(dataEnOut), .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  typedef struct {
    logic        de, hs, vs;
    logic [23:0] pix;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  // Behavioural reference state.
  int    accLo = 255, accHi = 0, actLo = 0, actHi = 255;
  bit    vsPrev = 0;
  string limTag = "R1";
  int unsigned seed = 32'h1234_5678;

  function automatic int nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) & 32'hFFFF);
  endfunction

  function automatic int rootRef(int v);
    return int'($floor($sqrt(real'(v))));
  endfunction

  function automatic int gammaRef(int sel, int s);
    if (sel == 1) return rootRef(255 * s);
    if (sel == 2) return (s * s * rootRef(255 * s)) / 65025;
    return s;
  endfunction

  function automatic int stretchRef(int v);
    longint p;
    int d;
    if (actHi <= actLo) return v;
    d = (v < actLo) ? 0 : v - actLo;
    p = longint'(d) * longint'((255 * 65536) / (actHi - actLo));
    p = p >> 16;
    if (p > 255) p = 255;
    return int'(p);
  endfunction

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic modelStep();
    exp_t e;
    int y, sel;
    bit rise;
    y    = int'(pixIn[23:16]);
    sel  = int'(gammaSel);
    rise = vsyncIn && !vsPrev;
    e.de = dataEnIn; e.hs = hsyncIn; e.vs = vsyncIn;
    e.pix = pixIn;
    if (sel == 3) begin
      e.pix[23:16] = 8'(y);
      e.tag = "R7";
    end else begin
      e.pix[23:16] = 8'(gammaRef(sel, stretchRef(y)));
      if (actHi <= actLo) e.tag = "R5";
      else if (sel != 0)  e.tag = "R6";
      else                e.tag = limTag;
    end
    expQ.push_back(e);
    if (rise) begin
      if (manualEn) begin
        actLo = int'(manualLo); actHi = int'(manualHi); limTag = "R8";
      end else begin
        actLo = accLo; actHi = accHi; limTag = "R3,R4";
      end
      accLo = 255; accHi = 0;
    end else if (dataEnIn) begin
      if (y < accLo) accLo = y;
      if (y > accHi) accHi = y;
    end
    vsPrev = vsyncIn;
  endtask

  task automatic compareOut();
    exp_t e;
    if (expQ.size() == 3) begin
      e = expQ.pop_front();
      check((e.tag == "R1") ? "R1" : "R2", int'({dataEnOut, hsyncOut, vsyncOut}),
            int'({e.de, e.hs, e.vs}));
      check((e.tag == "R1") ? "R1" : "R2", int'(pixOut[15:0]), int'(e.pix[15:0]));
      if (e.de) check(e.tag, int'(pixOut[23:16]), int'(e.pix[23:16]));
    end
  endtask

  task automatic cyc(input bit de, input bit hs, input bit vs, input int y, input int sel);
    @(negedge clk);
    compareOut();
    dataEnIn = de; hsyncIn = hs; vsyncIn = vs;
    gammaSel = 2'(sel);
    pixIn    = {8'(y), 16'(nextRand())};
    @(posedge clk);
    modelStep();
  endtask

  // One frame: optional vsync blank, then lines of valid pixels.
  task automatic frame(input bit blank, input int lines, input int width,
                       input int lo, input int hi, input bit rotate, input int fixedSel);
    int y;
    if (blank) begin
      for (int i = 0; i < 40; i++) cyc(0, 0, 1, 0, 0);
      for (int i = 0; i < 4; i++)  cyc(0, 0, 0, 0, 0);
    end
    for (int l = 0; l < lines; l++) begin
      for (int i = 0; i < 2; i++) cyc(0, 1, 0, 0, 0);
      for (int i = 0; i < 2; i++) cyc(0, 0, 0, 0, 0);
      for (int p = 0; p < width; p++) begin
        if (l == 0 && p == 0)      y = lo;
        else if (l == 0 && p == 1) y = hi;
        else                       y = lo + (nextRand() % (hi - lo + 1));
        cyc(1, 0, 0, y, rotate ? (p % 4) : fixedSel);
      end
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; pixIn = '0; dataEnIn = 0; hsyncIn = 0; vsyncIn = 0;
    gammaSel = '0; manualEn = 0; manualLo = '0; manualHi = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: first outputs after reset come from cleared registers.
    for (int i = 0; i < 2; i++) begin
      exp_t z;
      z.de = 0; z.hs = 0; z.vs = 0; z.pix = '0; z.tag = "R1";
      expQ.push_back(z);
    end
    frame(0, 3, 24, 60, 180, 0, 0);   // R1 identity limits
    frame(1, 3, 24, 60, 180, 0, 0);   // R3 R4 measured limits
    frame(1, 3, 32, 40, 200, 1, 0);   // R4 clamp and saturation, R6, R7
    frame(1, 2, 20, 100, 100, 0, 0);  // flat frame
    frame(1, 2, 32, 0, 255, 1, 0);    // R5 after flat frame
    frame(1, 0, 0, 0, 0, 0, 0);       // empty frame
    frame(1, 2, 20, 30, 90, 0, 0);    // R5 after empty frame
    frame(1, 2, 20, 10, 11, 0, 0);    // measured 30..90
    frame(1, 2, 24, 0, 255, 0, 0);    // span 1: R4 saturation
    manualEn = 1; manualLo = 8'd50; manualHi = 8'd150;
    frame(1, 2, 32, 0, 255, 1, 0);    // R8 manual limits
    manualLo = 8'd200; manualHi = 8'd100;
    frame(1, 2, 20, 0, 255, 0, 0);    // R8 with inverted limits: R5
    manualEn = 0;
    frame(1, 2, 24, 20, 220, 0, 0);   // back to measured limits
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule